// File: doc/BRIEF.md
# Initiator Phase-Checked Transfer Sequencer

This block runs the bus side of one block-move instruction for a device acting as initiator on a parallel REQ/ACK handshake bus. When the instruction is launched it first confirms that the device holds the initiator role. It then waits for the target to request a transfer with REQ. It captures the three phase lines and compares them with the phase the instruction expects. On a match it answers each request with ACK until the programmed number of bytes has moved. On a mismatch it raises an interrupt pulse and moves nothing further.

Two phases get special treatment. In message-out, an ATN condition that software raised is dropped during the last byte's handshake. In message-in, ACK is left asserted after the last byte until a separate clear command arrives, so that the initiator can decide whether to accept the message. All bus signals are active high inside the block. The data path, arbitration and selection sit outside it.

Top module: `xfer_phase_seq`

## Requirements
- R1: A `start` pulse while `is_initiator` is low executes nothing: `not_init_err` pulses for one cycle in the cycle after `start`, while `busy` and `ack` stay low.
- R2: `start` is taken only while the block is idle (`busy` low). It samples `instr_phase` and `byte_count`, and `busy` rises in the following cycle. A `start` while `busy` is high has no effect.
- R3: A REQ is unserviced when `req` is high while the block waits with `ack` low. On such a REQ the phase lines are captured, and `lat_phase` shows them one cycle later.
- R4: If the captured phase differs from the instruction phase, `mismatch_irq` pulses one cycle after the REQ is sampled. `ack` stays low, no `byte_stb` occurs and `busy` falls in that same cycle.
- R5: On a match, `ack` rises one cycle after the REQ is sampled. `ack` falls one cycle after `req` is sampled low, and `byte_stb` pulses in that same cycle.
- R6: A matching transfer of N bytes gives exactly N `byte_stb` pulses, and `done` pulses together with the last one. With a byte count of zero, `done` pulses one cycle after the matching REQ, and there is no ACK and no strobe.
- R7: In message-out phase (code 3'b110), `atn` falls in the same cycle that `ack` rises for the final byte. Earlier bytes leave `atn` unchanged.
- R8: In message-in phase (code 3'b111), `ack` stays high after the final byte's REQ falls. `done` and the last `byte_stb` pulse at that point, and `busy` stays high. A `clr_ack` pulse then drops `ack` and `busy` one cycle later.
- R9: `set_atn` drives `atn` high one cycle later. If it falls in the same cycle as the final message-out clear, the set wins.
- R10: Every later REQ of the transfer is compared again. A phase change part-way through raises `mismatch_irq`, with no ACK for that REQ, and ends the transfer.
- R11: `clr_ack` outside the held-ACK state has no effect. A `start` while ACK is held is ignored.
- Phase code bit order is {MSG, C/D, I/O}: data-out 3'b000, data-in 3'b001, status 3'b011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the instruction (one-cycle pulse) |
| is_initiator | input | 1 | Device currently holds the initiator role |
| instr_phase | input | 3 | Expected phase from the instruction |
| byte_count | input | CNT_W | Bytes to transfer |
| set_atn | input | 1 | Request to raise ATN |
| clr_ack | input | 1 | Command releasing a held ACK |
| req | input | 1 | Target request |
| phase_in | input | 3 | Bus phase lines {MSG, C/D, I/O} |
| ack | output | 1 | Initiator acknowledge |
| atn | output | 1 | Attention line |
| byte_stb | output | 1 | One pulse per completed byte handshake |
| done | output | 1 | Transfer complete pulse |
| mismatch_irq | output | 1 | Phase mismatch interrupt pulse |
| not_init_err | output | 1 | Instruction refused: not an initiator |
| busy | output | 1 | Instruction in progress, held ACK included |
| lat_phase | output | 3 | Phase captured on the last unserviced REQ |

## Verification
The ATN set request and the message-out final-byte clear can land in the same cycle. The bench provokes this by holding `set_atn` high through a whole message-out transfer, which makes the set coincide with the clear on the final ACK edge. It then expects `atn` to stay high throughout. A second collision is `start` arriving while message-in ACK is held, just before `clr_ack`. There the bench expects the start to be lost, with ACK and `busy` released only by the clear.

// File: rtl/xps_pkg.sv
package xps_pkg;
    localparam int PHASE_W = 3;
    typedef logic [PHASE_W-1:0] bus_phase_t;

    localparam bus_phase_t PH_MSG_OUT = 3'b110;
    localparam bus_phase_t PH_MSG_IN  = 3'b111;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_ACK,
        SQ_HOLD
    } seq_state_t;

    typedef struct packed {
        logic stb;
        logic done;
        logic irq;
        logic err;
    } seq_pulse_t;

    function automatic logic keeps_ack(bus_phase_t p);
        return p == PH_MSG_IN;
    endfunction

    function automatic logic drops_atn(bus_phase_t p);
        return p == PH_MSG_OUT;
    endfunction
endpackage

// File: rtl/xps_byte_counter.sv
module xps_byte_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_last
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec) begin
            remaining <= remaining - ONE;
        end
    end

    assign is_zero = (remaining == '0);
    assign is_last = (remaining == ONE);

    // R6: a byte is never counted out of an empty counter
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        dec |-> !is_zero);
endmodule

// File: rtl/xps_phase_latch.sv
module xps_phase_latch
    import xps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_load,
    input  bus_phase_t ref_in,
    input  logic       capture,
    input  bus_phase_t phase_in,
    output bus_phase_t ref_phase,
    output bus_phase_t lat_phase,
    output logic       match
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_phase <= '0;
            lat_phase <= '0;
        end else begin
            if (ref_load) ref_phase <= ref_in;
            if (capture)  lat_phase <= phase_in;
        end
    end

    assign match = (phase_in == ref_phase);

    // R3: captured lines appear one cycle after the unserviced REQ
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        capture |=> (lat_phase == $past(phase_in)));
endmodule

// File: rtl/xps_atn_ctrl.sv
module xps_atn_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_final,
    output logic atn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            atn <= 1'b0;
        end else if (set_req) begin
            atn <= 1'b1;
        end else if (clr_final) begin
            atn <= 1'b0;
        end
    end

    // R9: a set request is never lost, even against the final clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set_req |=> atn);
endmodule

// File: rtl/xfer_phase_seq.sv
module xfer_phase_seq
    import xps_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_initiator,
    input  logic [2:0]       instr_phase,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             set_atn,
    input  logic             clr_ack,
    input  logic             req,
    input  logic [2:0]       phase_in,
    output logic             ack,
    output logic             atn,
    output logic             byte_stb,
    output logic             done,
    output logic             mismatch_irq,
    output logic             not_init_err,
    output logic             busy,
    output logic [2:0]       lat_phase
);
    seq_state_t state;
    seq_pulse_t pulse;
    bus_phase_t ref_phase;
    logic       match;
    logic       is_zero;
    logic       is_last;
    logic       launch;
    logic       seen_req;
    logic       finish_byte;
    logic       final_atn_clr;

    assign launch        = (state == SQ_IDLE) && start && is_initiator;
    assign seen_req      = (state == SQ_WAIT) && req;
    assign finish_byte   = (state == SQ_ACK) && !req;
    assign final_atn_clr = seen_req && match && is_last && drops_atn(ref_phase);

    xps_byte_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .load_val (byte_count),
        .dec      (finish_byte),
        .is_zero  (is_zero),
        .is_last  (is_last)
    );

    xps_phase_latch u_ph (
        .clk       (clk),
        .rst       (rst),
        .ref_load  (launch),
        .ref_in    (instr_phase),
        .capture   (seen_req),
        .phase_in  (phase_in),
        .ref_phase (ref_phase),
        .lat_phase (lat_phase),
        .match     (match)
    );

    xps_atn_ctrl u_atn (
        .clk       (clk),
        .rst       (rst),
        .set_req   (set_atn),
        .clr_final (final_atn_clr),
        .atn       (atn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            ack   <= 1'b0;
            pulse <= '0;
        end else begin
            pulse <= '0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        if (!is_initiator) pulse.err <= 1'b1;
                        else               state     <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (req) begin
                        if (!match) begin
                            pulse.irq <= 1'b1;
                            state     <= SQ_IDLE;
                        end else if (is_zero) begin
                            pulse.done <= 1'b1;
                            state      <= SQ_IDLE;
                        end else begin
                            ack   <= 1'b1;
                            state <= SQ_ACK;
                        end
                    end
                end
                SQ_ACK: begin
                    if (!req) begin
                        pulse.stb <= 1'b1;
                        if (is_last) begin
                            pulse.done <= 1'b1;
                            if (keeps_ack(ref_phase)) begin
                                state <= SQ_HOLD;
                            end else begin
                                ack   <= 1'b0;
                                state <= SQ_IDLE;
                            end
                        end else begin
                            ack   <= 1'b0;
                            state <= SQ_WAIT;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (clr_ack) begin
                        ack   <= 1'b0;
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy         = (state != SQ_IDLE);
    assign byte_stb     = pulse.stb;
    assign done         = pulse.done;
    assign mismatch_irq = pulse.irq;
    assign not_init_err = pulse.err;

    // R5: ACK only ever answers a REQ seen in the previous cycle
    p_ack_after_req_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req));

    // R5: a handshake ACK is released only after REQ was seen low
    p_ack_release_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack) && $past(state) == SQ_ACK) |-> !$past(req));

    // R4: a mismatch moves no data and leaves the bus idle
    p_irq_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        mismatch_irq |-> (!ack && !byte_stb && !busy));

    // R1: a refused instruction never becomes busy
    p_refused_idle_r1: assert property (@(posedge clk) disable iff (rst)
        not_init_err |-> (!busy && !ack));

    // R6: end-of-instruction outcomes are mutually exclusive
    p_outcome_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, mismatch_irq, not_init_err}));

    // R7: ATN only drops together with a final ACK edge
    p_atn_drop_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(atn) |-> $rose(ack));

    // R8: a held ACK stays up until the clear command
    p_hold_ack_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == SQ_HOLD && !$past(clr_ack)) |-> ack);
endmodule

// File: tb/sim_xfer_phase_seq.sv
`timescale 1ns/1ps
module sim_xfer_phase_seq;
    localparam int CNT_W = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             is_initiator = 1'b1;
    logic [2:0]       instr_phase = 3'b000;
    logic [CNT_W-1:0] byte_count = '0;
    logic             set_atn = 1'b0;
    logic             clr_ack = 1'b0;
    logic             req = 1'b0;
    logic [2:0]       phase_in = 3'b000;
    logic             ack, atn, byte_stb, done, mismatch_irq, not_init_err, busy;
    logic [2:0]       lat_phase;

    xfer_phase_seq #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .is_initiator(is_initiator),
        .instr_phase(instr_phase), .byte_count(byte_count), .set_atn(set_atn),
        .clr_ack(clr_ack), .req(req), .phase_in(phase_in), .ack(ack), .atn(atn),
        .byte_stb(byte_stb), .done(done), .mismatch_irq(mismatch_irq),
        .not_init_err(not_init_err), .busy(busy), .lat_phase(lat_phase)
    );

    always #4 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string tag = "R2";
    bit    armed = 0;

    // target model
    bit       tgt_en = 0;
    int       served = 0;
    int       sw_at = 1000;
    logic [2:0] ph_a = 3'b000, ph_b = 3'b000;

    always @(negedge clk) begin
        if (rst) begin
            req = 1'b0;
        end else if (req) begin
            if (ack || !busy) begin
                req = 1'b0;
                if (ack) served++;
            end
        end else if (tgt_en && !ack && busy) begin
            phase_in = (served >= sw_at) ? ph_b : ph_a;
            req = 1'b1;
        end
    end

    // behavioural reference: mode 0 idle, 1 waiting, 2 acking, 3 holding
    int         m_mode = 0;
    int         m_rem = 0;
    int         m_iph = 0;
    logic       e_ack = 0, e_atn = 0, e_stb = 0, e_done = 0, e_irq = 0, e_err = 0;
    logic [2:0] e_lat = 0;

    always @(posedge clk) begin
        bit clear_atn;
        clear_atn = 0;
        if (rst) begin
            m_mode = 0; m_rem = 0; m_iph = 0;
            e_ack = 0; e_atn = 0; e_stb = 0; e_done = 0; e_irq = 0; e_err = 0; e_lat = 0;
        end else begin
            e_stb = 0; e_done = 0; e_irq = 0; e_err = 0;
            if (m_mode == 0) begin
                if (start) begin
                    if (!is_initiator) e_err = 1;
                    else begin
                        m_mode = 1; m_rem = int'(byte_count); m_iph = int'(instr_phase);
                    end
                end
            end else if (m_mode == 1) begin
                if (req) begin
                    e_lat = phase_in;
                    if (int'(phase_in) != m_iph) begin
                        e_irq = 1; m_mode = 0;
                    end else if (m_rem == 0) begin
                        e_done = 1; m_mode = 0;
                    end else begin
                        e_ack = 1; m_mode = 2;
                        if (m_rem == 1 && m_iph == 6) clear_atn = 1;
                    end
                end
            end else if (m_mode == 2) begin
                if (!req) begin
                    e_stb = 1;
                    if (m_rem == 1) begin
                        e_done = 1;
                        if (m_iph == 7) m_mode = 3;
                        else begin e_ack = 0; m_mode = 0; end
                    end else begin
                        e_ack = 0; m_rem--; m_mode = 1;
                    end
                end
            end else begin
                if (clr_ack) begin e_ack = 0; m_mode = 0; end
            end
            if (set_atn) e_atn = 1;
            else if (clear_atn) e_atn = 0;
        end
        armed = 1;
    end

    task automatic chk(string sig, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, sig, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            chk("ack R5",          int'(ack), int'(e_ack));
            chk("atn R7",          int'(atn), int'(e_atn));
            chk("byte_stb R6",     int'(byte_stb), int'(e_stb));
            chk("done R6",         int'(done), int'(e_done));
            chk("mismatch_irq R4", int'(mismatch_irq), int'(e_irq));
            chk("not_init_err R1", int'(not_init_err), int'(e_err));
            chk("busy R2",         int'(busy), int'(m_mode != 0));
            chk("lat_phase R3",    int'(lat_phase), int'(e_lat));
        end
    end

    task automatic launch(bit init, logic [2:0] iph, int cnt, logic [2:0] pa,
                          logic [2:0] pb, int sw);
        @(negedge clk);
        is_initiator = init; instr_phase = iph; byte_count = CNT_W'(cnt);
        ph_a = pa; ph_b = pb; sw_at = sw; served = 0; tgt_en = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=0", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        tag = "R1";  // refused when not initiator
        launch(0, 3'b000, 3, 3'b000, 3'b000, 1000); settle();

        tag = "R6";  // data-out, three bytes
        launch(1, 3'b000, 3, 3'b000, 3'b000, 1000); settle();

        tag = "R4";  // mismatch on first REQ
        launch(1, 3'b001, 2, 3'b011, 3'b011, 1000); settle();

        tag = "R6";  // zero count
        launch(1, 3'b001, 0, 3'b001, 3'b001, 1000); settle();

        tag = "R7";  // message-out drops ATN on last byte
        @(negedge clk); set_atn = 1'b1; @(negedge clk); set_atn = 1'b0;
        launch(1, 3'b110, 2, 3'b110, 3'b110, 1000); settle();

        tag = "R9";  // set_atn held across final clear
        @(negedge clk); set_atn = 1'b1;
        launch(1, 3'b110, 2, 3'b110, 3'b110, 1000); settle();
        set_atn = 1'b0;
        launch(1, 3'b110, 1, 3'b110, 3'b110, 1000); settle();

        tag = "R8";  // message-in holds ACK
        launch(1, 3'b111, 2, 3'b111, 3'b111, 1000);
        repeat (20) @(negedge clk);
        tag = "R11"; // start during hold ignored
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        tag = "R8";
        clr_ack = 1'b1; @(negedge clk); clr_ack = 1'b0;
        repeat (3) @(negedge clk);

        tag = "R11"; // clr_ack while idle
        clr_ack = 1'b1; @(negedge clk); clr_ack = 1'b0;
        repeat (2) @(negedge clk);

        tag = "R10"; // phase changes after two bytes
        launch(1, 3'b001, 4, 3'b001, 3'b011, 2);
        tag = "R2";  // start while busy ignored
        start = 1'b1; @(negedge clk); start = 1'b0;
        tag = "R10";
        settle();

        tag = "R3";  // status phase, one byte
        launch(1, 3'b011, 1, 3'b011, 3'b011, 1000); settle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule